// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block arbitrates eight interrupt request lines for a small 8-bit processor core. Software programs an enable register and two priority-bit registers through a simple write/read port. Each source takes one bit from each priority register, and the two bits together give it one of four levels. Every cycle the controller picks the single most urgent enabled request. It presents that request to the core as a registered pending flag, a source index and a vector address.

The core accepts the offered interrupt with an `ack` strobe and ends a handler with a `reti` strobe. A mask with one bit per level records which levels are in service. A request is offered only when its level is strictly above every level in service, so a higher-level request interrupts a lower-level handler, and the lower-level handler continues once the higher one returns. Sources selected by a parameter latch a high-to-low transition of their input into a flag, and that flag clears when the source is acknowledged. All other sources pass their live input level straight through as the request.

Top module: `nest_irq_ctrl`

## Requirements
- R1: With global enable set, source i (0..7) can raise `irq_pending` only while enable-register bit i is 1.
- R2: Enable-register bit 8 is the global enable; while it is 0 no source raises `irq_pending`, whatever bits 7..0 hold.
- R3: The level of source i is the 2-bit value {high-priority bit i, low-priority bit i}: 0 is lowest and 3 is highest, and the highest pending level wins regardless of source index.
- R4: A request is not offered while a handler of equal or higher level is in service; it is offered once that level is released.
- R5: A request whose level is strictly above every in-service level is offered and accepted while a lower-level handler is in service, and that lower level stays in service after the preempting handler returns.
- R6: Among pending requests of the same level, the lowest source index wins.
- R7: `irq_vector` equals 0x03 + 8 × `irq_src` (0x03, 0x0B, ... 0x3B) whenever `irq_pending` is 1.
- R8: Sources whose bit is set in parameter EDGE_MASK (default: sources 0 and 2) latch a high-to-low transition of `irq_in` into a request flag, and acknowledging that source clears the flag; the other sources use the live `irq_in` level, active high, and acknowledging them clears nothing.
- R9: The outputs are registered. An `ack` while `irq_pending` is 0 changes no state. After an accepted `ack`, `irq_pending` is 0 in the following cycle.
- R10: Register addresses: 0 is the enable register (9 bits), 1 is low priority, 2 is high priority, and 3 reads as zero. All registers read back what was written and reset to zero.
- R11: Accepting an `ack` marks the winner's level as in service; `reti` releases only the highest level in service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 9 | Register write data |
| reg_rdata | output | 9 | Register read data (combinational) |
| irq_in | input | 8 | Raw request lines, one per source |
| ack | input | 1 | Core accepts the offered interrupt |
| reti | input | 1 | Core returns from the current handler |
| irq_pending | output | 1 | An interrupt is offered |
| irq_src | output | 3 | Index of the offered source |
| irq_vector | output | 8 | Vector address of the offered source |

## Verification
The properties assume that `ack` and `reti` are never pulsed in the same cycle. They also assume the core issues `reti` only to end a handler it actually entered. Under those assumptions, the in-service mask changes by exactly one bit per strobe. The stimulus raises each strobe alone for a single cycle and pairs every accepted acknowledge with one later return. It leaves several settle cycles after every register write or request change, so the registered outputs have caught up before they are compared.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int unsigned LVL_W   = 2;
   localparam int unsigned NUM_LVL = 1 << LVL_W;

   typedef logic [LVL_W-1:0] lvl_t;

   typedef enum logic [1:0] {
      SEL_ENABLE = 2'd0,
      SEL_PRIO_L = 2'd1,
      SEL_PRIO_H = 2'd2,
      SEL_SPARE  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
   import intc_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [1:0]         addr,
   input  logic [NUM_SRC:0]   wdata,
   output logic [NUM_SRC:0]   rdata,
   output logic [NUM_SRC-1:0] src_en,
   output logic               glb_en,
   output logic [NUM_SRC-1:0] prio_l,
   output logic [NUM_SRC-1:0] prio_h
);
   logic [NUM_SRC:0]   ena_q;
   logic [NUM_SRC-1:0] pl_q;
   logic [NUM_SRC-1:0] ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena_q <= '0;
         pl_q  <= '0;
         ph_q  <= '0;
      end else if (we) begin
         case (reg_sel_e'(addr))
            SEL_ENABLE: ena_q <= wdata;
            SEL_PRIO_L: pl_q  <= wdata[NUM_SRC-1:0];
            SEL_PRIO_H: ph_q  <= wdata[NUM_SRC-1:0];
            default:    ;
         endcase
      end
   end

   always_comb begin
      case (reg_sel_e'(addr))
         SEL_ENABLE: rdata = ena_q;
         SEL_PRIO_L: rdata = {1'b0, pl_q};
         SEL_PRIO_H: rdata = {1'b0, ph_q};
         default:    rdata = '0;
      endcase
   end

   assign src_en = ena_q[NUM_SRC-1:0];
   assign glb_en = ena_q[NUM_SRC];
   assign prio_l = pl_q;
   assign prio_h = ph_q;
endmodule

// File: rtl/intc_req_capture.sv
module intc_req_capture #(
   parameter int unsigned NUM_SRC = 8,
   parameter logic [NUM_SRC-1:0] EDGE_MASK = '0,
   localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic               clr_valid,
   input  logic [IDX_W-1:0]   clr_idx,
   output logic [NUM_SRC-1:0] req
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (EDGE_MASK[i]) begin : g_edge
         logic prev_q;
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b1;
               flag_q <= 1'b0;
            end else begin
               prev_q <= irq_in[i];
               if (prev_q && !irq_in[i])
                  flag_q <= 1'b1;
               else if (clr_valid && clr_idx == IDX_W'(i))
                  flag_q <= 1'b0;
            end
         end
         assign req[i] = flag_q;
      end else begin : g_level
         assign req[i] = irq_in[i];
      end
   end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
   import intc_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] req,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic               glb_en,
   input  logic [NUM_SRC-1:0] prio_l,
   input  logic [NUM_SRC-1:0] prio_h,
   input  logic               top_valid,
   input  lvl_t               top_lvl,
   output logic               win_valid,
   output logic [IDX_W-1:0]   win_idx,
   output lvl_t               win_lvl
);
   logic found;
   lvl_t cur_lvl;

   always_comb begin
      found   = 1'b0;
      win_idx = '0;
      win_lvl = '0;
      cur_lvl = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         cur_lvl = {prio_h[i], prio_l[i]};
         if (glb_en && src_en[i] && req[i] && (!found || cur_lvl >= win_lvl)) begin
            found   = 1'b1;
            win_idx = IDX_W'(i);
            win_lvl = cur_lvl;
         end
      end
      win_valid = found && (!top_valid || win_lvl > top_lvl);
   end
endmodule

// File: rtl/intc_inservice.sv
module intc_inservice
   import intc_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  lvl_t               set_lvl,
   input  logic               pop,
   output logic [NUM_LVL-1:0] mask,
   output logic               top_valid,
   output lvl_t               top_lvl
);
   logic [NUM_LVL-1:0] mask_q;
   logic [NUM_LVL-1:0] mask_d;

   always_comb begin
      top_valid = |mask_q;
      top_lvl   = '0;
      for (int l = 0; l < NUM_LVL; l++)
         if (mask_q[l]) top_lvl = lvl_t'(l);
   end

   always_comb begin
      mask_d = mask_q;
      if (pop && top_valid) mask_d[top_lvl] = 1'b0;
      if (set_en)           mask_d[set_lvl] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end

   assign mask = mask_q;
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import intc_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 8,
   parameter logic [NUM_SRC-1:0] EDGE_MASK = 8'b0000_0101,
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned VEC_BASE = 3,
   parameter int unsigned VEC_STEP = 8,
   localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [1:0]         reg_addr,
   input  logic [NUM_SRC:0]   reg_wdata,
   output logic [NUM_SRC:0]   reg_rdata,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic               ack,
   input  logic               reti,
   output logic               irq_pending,
   output logic [IDX_W-1:0]   irq_src,
   output logic [VEC_W-1:0]   irq_vector
);
   if (NUM_SRC < 2) begin : g_bad_src
      $error("NUM_SRC must be at least 2");
   end
   if (VEC_BASE + VEC_STEP * (NUM_SRC - 1) >= (1 << VEC_W)) begin : g_bad_vec
      $error("vector range does not fit in VEC_W bits");
   end

   logic [NUM_SRC-1:0] src_en, prio_l, prio_h, req;
   logic               glb_en;
   logic               win_valid;
   logic [IDX_W-1:0]   win_idx;
   lvl_t               win_lvl;
   logic [NUM_LVL-1:0] isr_mask;
   logic               top_valid;
   lvl_t               top_lvl;

   logic               pend_q;
   logic [IDX_W-1:0]   src_q;
   lvl_t               lvl_q;
   logic [VEC_W-1:0]   vec_q;
   logic               ack_take;

   assign ack_take = ack && pend_q;

   intc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .src_en(src_en),
      .glb_en(glb_en), .prio_l(prio_l), .prio_h(prio_h)
   );

   intc_req_capture #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_cap (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .clr_valid(ack_take), .clr_idx(src_q), .req(req)
   );

   intc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
      .req(req), .src_en(src_en), .glb_en(glb_en),
      .prio_l(prio_l), .prio_h(prio_h),
      .top_valid(top_valid), .top_lvl(top_lvl),
      .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
   );

   intc_inservice u_isr (
      .clk(clk), .rst_n(rst_n), .set_en(ack_take), .set_lvl(lvl_q),
      .pop(reti), .mask(isr_mask), .top_valid(top_valid), .top_lvl(top_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         src_q  <= '0;
         lvl_q  <= '0;
         vec_q  <= '0;
      end else begin
         pend_q <= win_valid && !ack_take;
         src_q  <= win_idx;
         lvl_q  <= win_lvl;
         vec_q  <= VEC_W'(VEC_BASE + VEC_STEP * int'(win_idx));
      end
   end

   assign irq_pending = pend_q;
   assign irq_src     = src_q;
   assign irq_vector  = vec_q;
endmodule

// File: rtl/intc_sva.sv
module intc_sva
   import intc_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 8,
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned VEC_BASE = 3,
   parameter int unsigned VEC_STEP = 8,
   localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ack,
   input logic               reti,
   input logic               pend,
   input logic [IDX_W-1:0]   src,
   input logic [VEC_W-1:0]   vec,
   input lvl_t               lvl_q,
   input logic [NUM_LVL-1:0] isr,
   input logic               glb
);
   AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      !glb |=> !pend); // R2

   AST_PEND_ABOVE_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> ((isr >> lvl_q) == '0)); // R4

   AST_VECTOR_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> (vec == VEC_W'(VEC_BASE + VEC_STEP * int'(src)))); // R7

   AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !pend && !reti) |=> $stable(isr)); // R9

   AST_PEND_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && pend) |=> !pend); // R9

   AST_LEVEL_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && pend && !reti) |=> isr[$past(lvl_q)]); // R11

   AST_RETI_POPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && !ack && (isr != '0)) |=> ($countones(isr) + 1 == $countones($past(isr)))); // R11
endmodule

bind nest_irq_ctrl intc_sva #(
   .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_sva (
   .clk(clk), .rst_n(rst_n), .ack(ack), .reti(reti),
   .pend(irq_pending), .src(irq_src), .vec(irq_vector),
   .lvl_q(lvl_q), .isr(isr_mask), .glb(glb_en)
);

// File: tb/tb_nest_irq_ctrl.sv
`timescale 1ns/100ps
module tb_nest_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [8:0] reg_wdata = '0;
   logic [8:0] reg_rdata;
   logic [7:0] irq_in = 8'b0000_0101;
   logic       ack = 1'b0;
   logic       reti = 1'b0;
   logic       irq_pending;
   logic [2:0] irq_src;
   logic [7:0] irq_vector;

   int n_cmp = 0;
   int n_bad = 0;
   logic probe = 1'b0;

   typedef struct {
      logic       pend;
      logic [2:0] src;
      logic [7:0] vec;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   always #2.5 clk = ~clk;

   nest_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
      .ack(ack), .reti(reti), .irq_pending(irq_pending),
      .irq_src(irq_src), .irq_vector(irq_vector)
   );

   // monitor: compares the offered interrupt against the scoreboard
   always @(negedge clk) begin
      #1;
      if (probe) begin : cmp
         exp_t e;
         e = sb_q.pop_front();
         n_cmp++;
         if (irq_pending !== e.pend ||
             (e.pend && (irq_src !== e.src || irq_vector !== e.vec))) begin
            n_bad++;
            $display("FAIL %s: got pend=%0b src=%0d vec=%02h, exp pend=%0b src=%0d vec=%02h",
                     e.tag, irq_pending, irq_src, irq_vector, e.pend, e.src, e.vec);
         end
      end
   end

   task automatic expect_out(input bit p, input int s, input string tag, input bit do_ack);
      exp_t e;
      e.pend = p; e.src = 3'(s); e.vec = 8'(3 + 8 * s); e.tag = tag;
      @(negedge clk);
      sb_q.push_back(e);
      probe = 1'b1;
      ack   = do_ack;
      @(negedge clk);
      probe = 1'b0;
      ack   = 1'b0;
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = 9'(d);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic chk_rd(input int a, input int exp, input string tag);
      @(negedge clk);
      reg_addr = 2'(a);
      #1;
      n_cmp++;
      if (reg_rdata !== 9'(exp)) begin
         n_bad++;
         $display("FAIL %s: addr %0d got %03h exp %03h", tag, a, reg_rdata, 9'(exp));
      end
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic reti_pulse();
      @(negedge clk); reti = 1'b1;
      @(negedge clk); reti = 1'b0;
   endtask

   task automatic set_irq(input int i, input bit v);
      @(negedge clk);
      irq_in[i] = v;
   endtask

   task automatic fall_edge(input int i);
      set_irq(i, 1'b0);
      set_irq(i, 1'b1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      expect_out(0, 0, "R10 reset pending low", 0);
      chk_rd(0, 0, "R10 enable reset");
      chk_rd(1, 0, "R10 prio low reset");
      chk_rd(2, 0, "R10 prio high reset");
      wr(0, 'h0FF);
      chk_rd(0, 'h0FF, "R10 enable readback");
      wr(3, 'h1FF);
      chk_rd(3, 0, "R10 spare reads zero");
      // R2 global enable off
      set_irq(1, 1); settle();
      expect_out(0, 0, "R2 global off masks all", 0);
      // R1 individual enable
      wr(0, 'h1FD); settle();
      expect_out(0, 0, "R1 source1 disabled", 0);
      wr(0, 'h1FF); settle();
      expect_out(1, 1, "R1 source1 enabled", 0);
      // R6 tie at level 0, R4 equal-level blocking
      set_irq(3, 1); settle();
      expect_out(1, 1, "R6 lower index wins tie", 1);
      settle();
      expect_out(0, 0, "R4 equal level waits", 0);
      set_irq(1, 0); reti_pulse(); settle();
      expect_out(1, 3, "R11 reti releases level", 1);
      set_irq(3, 0); reti_pulse(); settle();
      expect_out(0, 0, "R11 all released idle", 0);
      // R3 level composition
      wr(1, 'b0000_0010); wr(2, 'b1000_0000);
      set_irq(1, 1); set_irq(7, 1); settle();
      expect_out(1, 7, "R3 high bit outranks low bit", 0);
      wr(2, 'b1000_0010); settle();
      expect_out(1, 1, "R3 both bits give level 3", 0);
      set_irq(1, 0); set_irq(7, 0);
      // R5 nesting: src5 level1, src4 level2, src6 level3
      wr(1, 'b0110_0000); wr(2, 'b0101_0000);
      set_irq(5, 1); settle();
      expect_out(1, 5, "R5 level1 handler entered", 1);
      set_irq(6, 1); settle();
      expect_out(1, 6, "R5 level3 preempts level1", 1);
      set_irq(4, 1); settle();
      expect_out(0, 0, "R4 level2 waits under level3", 0);
      set_irq(6, 0); reti_pulse(); settle();
      expect_out(1, 4, "R5 level2 preempts resumed level1", 1);
      set_irq(4, 0); reti_pulse(); settle();
      expect_out(0, 0, "R5 level1 still in service", 0);
      set_irq(5, 0); reti_pulse(); settle();
      expect_out(0, 0, "R11 nesting unwound", 0);
      wr(1, 0); wr(2, 0);
      // R9 ack with nothing pending
      expect_out(0, 0, "R9 idle ack", 1);
      set_irq(3, 1); settle();
      expect_out(1, 3, "R9 idle ack left mask clear", 1);
      set_irq(3, 0); reti_pulse(); settle();
      // R8 edge capture and clear
      fall_edge(0); settle();
      expect_out(1, 0, "R8 edge latched", 1);
      reti_pulse(); settle();
      expect_out(0, 0, "R8 edge flag cleared by ack", 0);
      set_irq(1, 1); settle();
      expect_out(1, 1, "R8 level source first", 1);
      reti_pulse(); settle();
      expect_out(1, 1, "R8 level source not cleared", 1);
      set_irq(1, 0); reti_pulse(); settle();
      // R7 vector per source
      for (int i = 1; i < 8; i++) begin
         if (i == 2) fall_edge(i);
         else        set_irq(i, 1);
         settle();
         expect_out(1, i, "R7 vector for source", 1);
         if (i != 2) set_irq(i, 0);
         reti_pulse(); settle();
      end
      expect_out(0, 0, "R7 sweep ends idle", 0);
      repeat (3) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule